// File: doc/BRIEF.md
# Multi-Issue Field-Arithmetic Dispatcher with Dependency Scoreboard

This block sits between a host and a bank of identical fixed-latency field-arithmetic units. The host hands over three-source, one-destination instructions (the shape of a multiply-accumulate `x*y+z`) on a valid/ready stream. Accepted instructions wait in an eight-entry queue, and each cycle the dispatcher sends as many of them as there are idle units. It keeps one busy flag per register of a sixteen-entry register file, so that no instruction reads a value that has not yet been written.

Each instruction moves through four stages: decode, operand read, execute and result write. The operand-read time grows with the operation code, and the execute time is a fixed parameter. All units share one result-write port. When several units finish together they queue for that port, so the write time of a batch grows with the number of instructions issued together. Younger instructions may overtake older ones that are stalled, as long as no register hazard would result.

Back-pressure rule: an instruction transfers on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` depends only on queue occupancy and never on `in_valid`. While `in_ready` is low the host must keep its instruction stable and wait.

Top module: `ffu_dispatch`

## Requirements
- R1: After reset the queue is empty, `in_ready` is 1, `q_full` is 0, `iss_mask` is 0, `wr_valid` is 0 and no register is marked busy.
- R2: An instruction is accepted exactly on a cycle with `in_valid` and `in_ready` high. `in_ready` is 0 and `q_full` is 1 exactly when 8 instructions are queued. While that holds, nothing is accepted.
- R3: An instruction with operation code `op` (0..3) that issues in cycle t raises its write request in cycle t + op + 1 + EX_LAT. `wr_valid` shows it then if the write port is free.
- R4: An instruction does not issue while any of its three sources is the destination of an in-flight instruction, or of an older instruction still queued.
- R5: An instruction does not issue while its destination is busy, is the destination of an older queued instruction, or is a source of an older queued instruction.
- R6: A younger instruction with no hazard issues ahead of an older stalled one.
- R7: Each cycle, hazard-free queued instructions issue oldest first, one per idle unit. Units are filled in ascending index order. Bit u of `iss_mask` is high in the cycle an instruction is sent to unit u.
- R8: At most one result is written per cycle. Among units requesting the port, the one with the lowest index wins, and the others hold their request.
- R9: A busy flag clears at the end of the write cycle of its producer. A stalled consumer issues in the following cycle if a unit is idle.
- R10: An instruction accepted in cycle t can issue no earlier than cycle t+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Host offers an instruction |
| in_ready | output | 1 | Queue can take an instruction |
| in_op | input | 2 | Operation code; sets operand-read cycles (op+1) |
| in_dst | input | 4 | Destination register |
| in_src_a | input | 4 | Source register x |
| in_src_b | input | 4 | Source register y |
| in_src_c | input | 4 | Source register z |
| q_full | output | 1 | Queue holds 8 instructions |
| iss_mask | output | 4 | One bit per unit, high in the cycle that unit receives an instruction |
| wr_valid | output | 1 | A result is written this cycle |
| wr_unit | output | 2 | Index of the unit writing |
| wr_dst | output | 4 | Register being written |

## Verification
On every cycle, the embedded assertions check the following. The queue count moves exactly by pushes minus issues, and nothing enters a full queue. Units are loaded only while idle and stay silent right after loading. The write grant is one-hot within the requests. A flag is never set twice, and every written register was marked busy. Whether the right instruction went to the right unit at the right time can only be shown by the bench. The same holds for overtaking past a stalled instruction, the exact write cycle per operation code, and the release of a stalled consumer one cycle after its producer writes. The bench compares these against a behavioural model, on directed hazard chains, on a full-queue stall and on random streams.

// File: rtl/dsp_pkg.sv
package dsp_pkg;
  localparam int REG_W = 4;
  localparam int OP_W  = 2;
  localparam int NREG  = 1 << REG_W;

  typedef struct packed {
    logic [OP_W-1:0]  op;
    logic [REG_W-1:0] dst;
    logic [REG_W-1:0] sa;
    logic [REG_W-1:0] sb;
    logic [REG_W-1:0] sc;
  } instr_t;
endpackage

// File: rtl/dsp_queue.sv
module dsp_queue
  import dsp_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 push,
  input  instr_t               push_data,
  input  logic [DEPTH-1:0]     pop,
  output instr_t [DEPTH-1:0]   ents,
  output logic [DEPTH-1:0]     vld,
  output logic                 full
);
  localparam int CW = $clog2(DEPTH + 1);

  instr_t [DEPTH-1:0] ents_q, ents_n;
  logic [CW-1:0]      cnt_q, cnt_n;

  // compact survivors towards index 0 (oldest), then append
  always_comb begin
    int k;
    ents_n = ents_q;
    k = 0;
    for (int i = 0; i < DEPTH; i++) begin
      if (vld[i] && !pop[i]) begin
        ents_n[k] = ents_q[i];
        k++;
      end
    end
    if (push && k < DEPTH) begin
      ents_n[k] = push_data;
      k++;
    end
    cnt_n = CW'(k);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      ents_q <= '0;
    end else begin
      cnt_q  <= cnt_n;
      ents_q <= ents_n;
    end
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) vld[i] = (CW'(i) < cnt_q);
  end

  assign ents = ents_q;
  assign full = (cnt_q == CW'(DEPTH));

  logic past_ok;
  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (int'(cnt_q) == int'($past(cnt_q)) + int'($past(push)) - $countones($past(pop))));
  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push);
endmodule

// File: rtl/dsp_pick.sv
module dsp_pick
  import dsp_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int NU    = 4
) (
  input  instr_t [DEPTH-1:0] ents,
  input  logic [DEPTH-1:0]   vld,
  input  logic [NREG-1:0]    busy,
  input  logic [NU-1:0]      ufree,
  output logic [DEPTH-1:0]   pop,
  output logic [NU-1:0]      load,
  output instr_t [NU-1:0]    load_ins
);
  logic [DEPTH-1:0] hz;

  // hazards against in-flight results and against older queued entries
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      hz[i] = busy[ents[i].sa] | busy[ents[i].sb] | busy[ents[i].sc] | busy[ents[i].dst];
      for (int j = 0; j < DEPTH; j++) begin
        if (j < i && vld[j]) begin
          if (ents[j].dst == ents[i].sa || ents[j].dst == ents[i].sb ||
              ents[j].dst == ents[i].sc || ents[j].dst == ents[i].dst ||
              ents[i].dst == ents[j].sa || ents[i].dst == ents[j].sb ||
              ents[i].dst == ents[j].sc)
            hz[i] = 1'b1;
        end
      end
    end
  end

  // oldest ready entries go to the lowest idle units
  always_comb begin
    logic [NU-1:0] used;
    logic placed;
    pop      = '0;
    load     = '0;
    load_ins = '0;
    used     = '0;
    for (int i = 0; i < DEPTH; i++) begin
      placed = 1'b0;
      if (vld[i] && !hz[i]) begin
        for (int u = 0; u < NU; u++) begin
          if (!placed && ufree[u] && !used[u]) begin
            used[u]     = 1'b1;
            load[u]     = 1'b1;
            load_ins[u] = ents[i];
            pop[i]      = 1'b1;
            placed      = 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/dsp_unit.sv
module dsp_unit
  import dsp_pkg::*;
#(
  parameter int EX_LAT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [OP_W-1:0]  load_op,
  input  logic [REG_W-1:0] load_dst,
  input  logic             gnt,
  output logic             req,
  output logic             free,
  output logic [REG_W-1:0] dst
);
  localparam int MAXC = (1 << OP_W) + EX_LAT;
  localparam int CW   = $clog2(MAXC + 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic [REG_W-1:0] dst_q;

  // operand read (op+1) plus execute (EX_LAT), minus the issue cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      dst_q  <= '0;
    end else if (load) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(load_op) + CW'(EX_LAT);
      dst_q  <= load_dst;
    end else if (gnt) begin
      busy_q <= 1'b0;
    end else if (busy_q && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign req  = busy_q && (cnt_q == '0);
  assign free = !busy_q;
  assign dst  = dst_q;

  // R7
  load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> free);
  // R3
  no_early_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !req);
endmodule

// File: rtl/dsp_wport.sv
module dsp_wport #(
  parameter int NU = 4,
  parameter int UW = (NU > 1) ? $clog2(NU) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NU-1:0] req,
  output logic [NU-1:0] gnt,
  output logic          any,
  output logic [UW-1:0] idx
);
  always_comb begin
    gnt = '0;
    any = 1'b0;
    idx = '0;
    for (int u = 0; u < NU; u++) begin
      if (req[u] && !any) begin
        gnt[u] = 1'b1;
        any    = 1'b1;
        idx    = UW'(u);
      end
    end
  end

  // R8
  one_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt) && ((gnt & ~req) == '0));
  // R8
  loser_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (any && (req & ~gnt) != '0) |=> (req != '0));
endmodule

// File: rtl/ffu_dispatch.sv
module ffu_dispatch
  import dsp_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int NU     = 4,
  parameter int EX_LAT = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [OP_W-1:0]      in_op,
  input  logic [REG_W-1:0]     in_dst,
  input  logic [REG_W-1:0]     in_src_a,
  input  logic [REG_W-1:0]     in_src_b,
  input  logic [REG_W-1:0]     in_src_c,
  output logic                 q_full,
  output logic [NU-1:0]        iss_mask,
  output logic                 wr_valid,
  output logic [((NU > 1) ? $clog2(NU) : 1)-1:0] wr_unit,
  output logic [REG_W-1:0]     wr_dst
);
  localparam int UW = (NU > 1) ? $clog2(NU) : 1;

  instr_t             push_data;
  logic               push, full;
  instr_t [DEPTH-1:0] ents;
  logic [DEPTH-1:0]   vld, pop;
  logic [NU-1:0]      load, ufree, ureq, gnt;
  instr_t [NU-1:0]    load_ins;
  logic [REG_W-1:0]   udst [NU];
  logic [NREG-1:0]    busy_q, busy_set, busy_clr;

  assign push_data = '{op: in_op, dst: in_dst, sa: in_src_a, sb: in_src_b, sc: in_src_c};
  assign in_ready  = !full;
  assign push      = in_valid && !full;
  assign q_full    = full;

  dsp_queue #(.DEPTH(DEPTH)) u_queue (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
    .pop(pop), .ents(ents), .vld(vld), .full(full)
  );

  dsp_pick #(.DEPTH(DEPTH), .NU(NU)) u_pick (
    .ents(ents), .vld(vld), .busy(busy_q), .ufree(ufree),
    .pop(pop), .load(load), .load_ins(load_ins)
  );

  for (genvar u = 0; u < NU; u++) begin : g_unit
    dsp_unit #(.EX_LAT(EX_LAT)) u_unit (
      .clk(clk), .rst_n(rst_n), .load(load[u]),
      .load_op(load_ins[u].op), .load_dst(load_ins[u].dst),
      .gnt(gnt[u]), .req(ureq[u]), .free(ufree[u]), .dst(udst[u])
    );
  end

  dsp_wport #(.NU(NU), .UW(UW)) u_wport (
    .clk(clk), .rst_n(rst_n), .req(ureq), .gnt(gnt), .any(wr_valid), .idx(wr_unit)
  );

  always_comb begin
    wr_dst = '0;
    for (int u = 0; u < NU; u++) if (gnt[u]) wr_dst = udst[u];
  end

  // scoreboard: flag set on issue, cleared on the producer's write
  always_comb begin
    busy_set = '0;
    for (int u = 0; u < NU; u++) if (load[u]) busy_set[load_ins[u].dst] = 1'b1;
    busy_clr = '0;
    if (wr_valid) busy_clr[wr_dst] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) busy_q <= '0;
    else        busy_q <= (busy_q & ~busy_clr) | busy_set;
  end

  assign iss_mask = load;

  // R5
  no_double_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_set & busy_q) == '0);
  // R9
  write_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> busy_q[wr_dst]);
  // R9
  write_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !busy_q[$past(wr_dst)]);
endmodule

// File: tb/tb_ffu_dispatch.sv
`timescale 1ns/1ps
module tb_ffu_dispatch;
  import dsp_pkg::*;

  localparam int DEPTH = 8;
  localparam int NU    = 4;
  localparam int EX    = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready, q_full, wr_valid;
  logic [1:0] in_op = '0;
  logic [3:0] in_dst = '0, in_src_a = '0, in_src_b = '0, in_src_c = '0;
  logic [3:0] iss_mask;
  logic [1:0] wr_unit;
  logic [3:0] wr_dst;

  always #2.5 clk = ~clk;

  ffu_dispatch #(.DEPTH(DEPTH), .NU(NU), .EX_LAT(EX)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_dst(in_dst), .in_src_a(in_src_a), .in_src_b(in_src_b),
    .in_src_c(in_src_c), .q_full(q_full), .iss_mask(iss_mask),
    .wr_valid(wr_valid), .wr_unit(wr_unit), .wr_dst(wr_dst)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  // behavioural reference state
  instr_t mq[$];
  bit     mbusy[16];
  bit     mub[4];
  int     mcnt[4];
  int     mud[4];

  int sidx;
  int s_mask, s_wv, s_wu, s_wd, s_rdy, s_full;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (step %0d)", tag, act, exp, sidx);
    end
  endtask

  function automatic instr_t mk(int op, int d, int a, int b, int c);
    instr_t t;
    t.op = 2'(op); t.dst = 4'(d); t.sa = 4'(a); t.sb = 4'(b); t.sc = 4'(c);
    return t;
  endfunction

  function automatic bit clash(instr_t o, instr_t y);
    return (o.dst == y.sa) || (o.dst == y.sb) || (o.dst == y.sc) || (o.dst == y.dst) ||
           (y.dst == o.sa) || (y.dst == o.sb) || (y.dst == o.sc);
  endfunction

  task automatic step(input bit v, input instr_t ins, output bit acc);
    int ewu, np, emask, erdy;
    int pidx[8];
    int pu[8];
    bit used[4];
    in_valid = v; in_op = ins.op; in_dst = ins.dst;
    in_src_a = ins.sa; in_src_b = ins.sb; in_src_c = ins.sc;
    #1;
    ewu = -1;
    for (int u = 0; u < NU; u++) if (ewu < 0 && mub[u] && mcnt[u] == 0) ewu = u;
    np = 0; emask = 0;
    for (int u = 0; u < NU; u++) used[u] = 0;
    for (int i = 0; i < mq.size(); i++) begin
      bit h;
      h = mbusy[mq[i].sa] | mbusy[mq[i].sb] | mbusy[mq[i].sc] | mbusy[mq[i].dst];
      for (int j = 0; j < i; j++) if (clash(mq[j], mq[i])) h = 1;
      if (!h) begin
        for (int u = 0; u < NU; u++) begin
          if (!mub[u] && !used[u]) begin
            used[u] = 1; pidx[np] = i; pu[np] = u; np++; emask |= (1 << u);
            break;
          end
        end
      end
    end
    erdy = (mq.size() < DEPTH) ? 1 : 0;
    s_mask = int'(iss_mask); s_wv = int'(wr_valid); s_wu = int'(wr_unit);
    s_wd = int'(wr_dst); s_rdy = int'(in_ready); s_full = int'(q_full);
    chk("R7 issue mask", s_mask, emask);
    chk("R2 in_ready", s_rdy, erdy);
    chk("R2 q_full", s_full, 1 - erdy);
    chk("R8 wr_valid", s_wv, (ewu >= 0) ? 1 : 0);
    if (ewu >= 0) begin
      chk("R8 wr_unit", s_wu, ewu);
      chk("R9 wr_dst", s_wd, mud[ewu]);
    end
    acc = v && (erdy == 1);
    // advance the model to the next cycle
    if (ewu >= 0) begin mub[ewu] = 0; mbusy[mud[ewu]] = 0; end
    for (int u = 0; u < NU; u++) if (mub[u] && mcnt[u] > 0) mcnt[u]--;
    for (int k = 0; k < np; k++) begin
      mub[pu[k]] = 1; mcnt[pu[k]] = int'(mq[pidx[k]].op) + EX;
      mud[pu[k]] = int'(mq[pidx[k]].dst); mbusy[mq[pidx[k]].dst] = 1;
    end
    for (int k = np - 1; k >= 0; k--) mq.delete(pidx[k]);
    if (acc) mq.push_back(ins);
    @(negedge clk);
    sidx++;
  endtask

  task automatic idle(input int n);
    bit a;
    for (int k = 0; k < n; k++) step(0, '0, a);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL R1 watchdog expired actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    bit a;
    instr_t d8;
    for (int r = 0; r < 16; r++) mbusy[r] = 0;
    for (int u = 0; u < NU; u++) begin mub[u] = 0; mcnt[u] = 0; mud[u] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 in_ready", int'(in_ready), 1);
    chk("R1 q_full", int'(q_full), 0);
    chk("R1 iss_mask", int'(iss_mask), 0);
    chk("R1 wr_valid", int'(wr_valid), 0);
    @(negedge clk);

    // scenario A: RAW stall, overtaking, WAR/WAW hold
    sidx = 0;
    step(1, mk(0, 1, 2, 3, 4), a);
    chk("R10 no same-cycle issue", s_mask, 0);
    step(1, mk(0, 5, 1, 1, 1), a);
    chk("R7 first issue to unit0", s_mask, 1);
    step(1, mk(0, 6, 7, 8, 9), a);
    step(1, mk(0, 1, 10, 11, 12), a);
    chk("R6 younger overtakes stalled", s_mask, 2);
    step(0, '0, a);
    chk("R3 op0 write cycle", s_wv * 100 + s_wu * 16 + s_wd, 100 + 0 + 1);
    chk("R4 consumer held while source busy", s_mask, 0);
    step(0, '0, a);
    chk("R9 consumer issues after write", s_mask, 1);
    chk("R5 WAR/WAW instruction held", s_mask & 4, 0);
    step(0, '0, a);
    chk("R5 WAW/WAR instruction released", s_mask, 4);
    idle(12);

    // scenario C: long chain, full queue, write-port contention
    sidx = 0;
    step(1, mk(3, 1, 0, 0, 0), a);
    step(1, mk(3, 14, 1, 1, 1), a);
    for (int k = 0; k < 8; k++) begin
      step(1, mk(0, 2 + k, 14, 14, 14), a);
      if (sidx == 7) chk("R3 op3 no early write", s_wv, 0);
      if (sidx == 8) chk("R3 op3 write cycle", s_wv * 16 + s_wd, 16 + 1);
      if (sidx == 10) chk("R2 ready before full", s_rdy, 1);
    end
    d8 = mk(0, 10, 14, 14, 14);
    a = 0;
    while (!a) begin
      step(1, d8, a);
      if (sidx == 11) chk("R2 full blocks accept", s_rdy * 2 + s_full, 1);
      if (sidx == 16) chk("R7 four issue at once", s_mask, 15);
    end
    for (int k = 0; k < 8; k++) begin
      step(0, '0, a);
      if (sidx == 19) chk("R8 unit0 wins port", s_wu * 16 + s_wd, 0 + 2);
      if (sidx == 20) chk("R8 unit1 next", s_wu * 16 + s_wd, 16 + 3);
      if (sidx == 22) chk("R8 unit3 last", s_wu * 16 + s_wd, 48 + 5);
    end
    idle(16);

    // random streams with a small register window for frequent hazards
    for (int n = 0; n < 600; n++) begin
      instr_t t;
      t = mk($urandom % 4, $urandom % 6, $urandom % 6, $urandom % 6, $urandom % 6);
      if ($urandom % 4 != 0) begin
        a = 0;
        while (!a) step(1, t, a);
      end else begin
        step(0, '0, a);
      end
    end
    idle(40);
    chk("R1 drained queue ready", s_rdy, 1);
    done = 1;
    summary();
    $finish;
  end
endmodule